// File: doc/BRIEF.md
# Memory-Stall Phase Detection Table

The block watches the retire stream of a single-issue in-order core and finds loops where one instruction keeps stalling on main memory at a regular interval. Each table entry is keyed by the program counter of a stalling instruction. It measures two things between successive stalls of that instruction: the clock cycles that pass (the stride) and the instructions that retire (the work count). A saturating confidence counter and a four-state entry machine (Invalid, Attempt, Tentative, Valid) decide when the loop is steady enough to call the phase memory-bound.

When an entry turns Valid while the core runs at full speed, the block raises a slow-down interrupt and holds the stride and work count of that entry on its outputs. Software divides these figures to get the slowdown factor and picks a voltage and frequency pair. When no Valid entry remains while the core runs slow, the block raises a speed-up interrupt. The speed flag changes only when software acknowledges the request. An owner tag is stored with each entry and compared under an operating-system mask, so entries survive context switches.

Entry transitions: *allocate* (Invalid or victim to Attempt, on a stall that misses), *confirm* (Attempt to Tentative, on the second stall), *lock* (Tentative to Valid, on a stall whose stride is close), *reinforce* (Valid stays Valid with Q raised), *weaken* (Tentative or Valid keeps its state with Q lowered), *drop* (to Invalid when Q reaches zero). Speed controller states: FAST, REQ_SLOW, SLOW, REQ_FAST. FAST goes to REQ_SLOW when any entry is Valid. REQ_SLOW goes to SLOW on acknowledge. SLOW goes to REQ_FAST when no entry is Valid. REQ_FAST goes to FAST on acknowledge.

Top module: `stall_phase_table`

## Requirements
- R1: After reset every entry is Invalid, `irq_o`, `irq_speedup_o` and `slowed_o` are 0, and `ninstr_o` and `stride_o` are 0. The owner register resets to 0 and the mask resets to all ones.
- R2: A retire without `mem_stall_i` never allocates or disturbs an entry. A stall whose PC misses allocates one entry in Attempt with Q=1 and the current owner tag.
- R3: The second hit stall moves Attempt to Tentative. A later hit stall with a close stride moves Tentative to Valid. The stride is the number of clock edges from one stall of that PC to the next. The work count is the number of retire strobes after the previous stall up to and including the current one. These values are latched on the outputs when the slow-down request is made.
- R4: A measured stride m is close to the stored stride s when |m - s| <= floor(s/8). Every hit stall in Tentative or Valid stores the new measurement.
- R5: Q is 2 bits wide. A close stride raises Q, saturating at 3. A far stride lowers Q, and the entry drops to Invalid when Q reaches 0.
- R6: A lookup hits only if the state is not Invalid, the PC is equal, and (tag & mask) == (owner & mask). With `cfg_we_i`, `cfg_sel_i`=0 writes the owner register and `cfg_sel_i`=1 writes the mask. When more than one entry hits, the lowest index wins.
- R7: On a miss with no Invalid entry, the entry with the lowest Q is replaced, and a tie goes to the lowest index.
- R8: The stride and the work count saturate at 2^CNT_W - 1.
- R9: One clock edge after some entry is Valid while in FAST, `irq_o`=1 and `irq_speedup_o`=0. The request holds until `irq_ack_i`, and only then does `slowed_o` become 1.
- R10: While slowed, one edge after no entry is Valid, `irq_o`=1 and `irq_speedup_o`=1. The request holds until `irq_ack_i`, which then clears `slowed_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| retire_pc_i | input | PC_W | PC of the retiring or stalling instruction |
| mem_stall_i | input | 1 | The instruction at `retire_pc_i` stalled on main memory |
| cfg_we_i | input | 1 | Write strobe for the owner and mask registers |
| cfg_sel_i | input | 1 | 0 selects the owner register, 1 selects the mask |
| cfg_wdata_i | input | ID_W | Data for the register write |
| irq_ack_i | input | 1 | Software acknowledges the pending request |
| irq_o | output | 1 | Speed-change request pending |
| irq_speedup_o | output | 1 | 1 = speed-up request, 0 = slow-down request |
| slowed_o | output | 1 | The core currently runs at reduced speed |
| ninstr_o | output | CNT_W | Latched work count of the triggering entry |
| stride_o | output | CNT_W | Latched stride of the triggering entry |

## Verification
The assertions assume that software sends `irq_ack_i` only while a request is pending, and that it holds the owner and mask steady around a stall that it expects to hit. The stimulus pulses the acknowledge only after it has seen `irq_o` high. It writes configuration only in cycles with no stall, and it gives non-stalling retires addresses that never match a tracked PC. The random trials stay below the counter limit, so closeness can be predicted from exact integers; saturation is exercised by separate directed cases.

// File: rtl/stall_phase_pkg.sv
package stall_phase_pkg;

    localparam int unsigned Q_W = 2;

    typedef enum logic [1:0] {
        ENT_INVALID   = 2'd0,
        ENT_ATTEMPT   = 2'd1,
        ENT_TENTATIVE = 2'd2,
        ENT_VALID     = 2'd3
    } ent_state_e;

    typedef enum logic [1:0] {
        SPD_FAST     = 2'd0,
        SPD_REQ_SLOW = 2'd1,
        SPD_SLOW     = 2'd2,
        SPD_REQ_FAST = 2'd3
    } spd_state_e;

endpackage

// File: rtl/stall_entry.sv
module stall_entry
    import stall_phase_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned ID_W  = 8,
    parameter int unsigned CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                retire_i,
    input  logic                stall_hit_i,
    input  logic                alloc_i,
    input  logic [PC_W-1:0]     pc_i,
    input  logic [ID_W-1:0]     id_i,
    output ent_state_e          state_o,
    output logic [PC_W-1:0]     pc_o,
    output logic [ID_W-1:0]     id_o,
    output logic [Q_W-1:0]      q_o,
    output logic [CNT_W-1:0]    stride_o,
    output logic [CNT_W-1:0]    ninstr_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [Q_W-1:0]   Q_MAX   = '1;
    localparam logic [Q_W-1:0]   Q_ONE   = Q_W'(1);

    ent_state_e        state_q, state_d;
    logic [PC_W-1:0]   pc_q, pc_d;
    logic [ID_W-1:0]   id_q, id_d;
    logic [Q_W-1:0]    q_q, q_d;
    logic [CNT_W-1:0]  ccnt_q, ccnt_d;
    logic [CNT_W-1:0]  icnt_q, icnt_d;
    logic [CNT_W-1:0]  stride_q, stride_d;
    logic [CNT_W-1:0]  ninstr_q, ninstr_d;

    logic [CNT_W-1:0]  meas_s, meas_n, gap;
    logic              close;

    // Interval measured at a hit stall, clamped to the counter width.
    assign meas_s = (ccnt_q == CNT_MAX) ? CNT_MAX : ccnt_q + 1'b1;
    assign meas_n = (retire_i && (icnt_q != CNT_MAX)) ? icnt_q + 1'b1 : icnt_q;
    assign gap    = (meas_s >= stride_q) ? (meas_s - stride_q) : (stride_q - meas_s);
    assign close  = (gap <= (stride_q >> 3));

    always_comb begin
        state_d  = state_q;
        pc_d     = pc_q;
        id_d     = id_q;
        q_d      = q_q;
        stride_d = stride_q;
        ninstr_d = ninstr_q;
        ccnt_d   = (ccnt_q == CNT_MAX) ? CNT_MAX : ccnt_q + 1'b1;
        icnt_d   = (retire_i && (icnt_q != CNT_MAX)) ? icnt_q + 1'b1 : icnt_q;
        if (alloc_i) begin
            state_d  = ENT_ATTEMPT;
            pc_d     = pc_i;
            id_d     = id_i;
            q_d      = Q_ONE;
            ccnt_d   = '0;
            icnt_d   = '0;
            stride_d = '0;
            ninstr_d = '0;
        end else if (stall_hit_i) begin
            ccnt_d   = '0;
            icnt_d   = '0;
            stride_d = meas_s;
            ninstr_d = meas_n;
            unique case (state_q)
                ENT_ATTEMPT: state_d = ENT_TENTATIVE;
                ENT_TENTATIVE, ENT_VALID: begin
                    if (close) begin
                        state_d = ENT_VALID;
                        q_d     = (q_q == Q_MAX) ? q_q : q_q + 1'b1;
                    end else if (q_q <= Q_ONE) begin
                        state_d = ENT_INVALID;
                        q_d     = '0;
                    end else begin
                        q_d     = q_q - 1'b1;
                    end
                end
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ENT_INVALID;
            pc_q     <= '0;
            id_q     <= '0;
            q_q      <= '0;
            ccnt_q   <= '0;
            icnt_q   <= '0;
            stride_q <= '0;
            ninstr_q <= '0;
        end else begin
            state_q  <= state_d;
            pc_q     <= pc_d;
            id_q     <= id_d;
            q_q      <= q_d;
            ccnt_q   <= ccnt_d;
            icnt_q   <= icnt_d;
            stride_q <= stride_d;
            ninstr_q <= ninstr_d;
        end
    end

    assign state_o  = state_q;
    assign pc_o     = pc_q;
    assign id_o     = id_q;
    assign q_o      = q_q;
    assign stride_o = stride_q;
    assign ninstr_o = ninstr_q;

endmodule

// File: rtl/stall_select.sv
module stall_select
    import stall_phase_pkg::*;
#(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned PC_W    = 32,
    parameter int unsigned ID_W    = 8,
    parameter int unsigned IDX_W   = 2
) (
    input  logic [ENTRIES-1:0][1:0]      st_i,
    input  logic [ENTRIES-1:0][PC_W-1:0] pc_i,
    input  logic [ENTRIES-1:0][ID_W-1:0] id_i,
    input  logic [ENTRIES-1:0][Q_W-1:0]  q_i,
    input  logic [PC_W-1:0]              look_pc_i,
    input  logic [ID_W-1:0]              owner_i,
    input  logic [ID_W-1:0]              mask_i,
    output logic                         hit_o,
    output logic [IDX_W-1:0]             hit_idx_o,
    output logic [IDX_W-1:0]             vic_idx_o,
    output logic                         any_valid_o,
    output logic [IDX_W-1:0]             val_idx_o
);

    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign match[g] = (st_i[g] != ENT_INVALID) &&
                          (pc_i[g] == look_pc_i) &&
                          (((id_i[g] ^ owner_i) & mask_i) == '0);
    end

    logic             have_inv;
    logic [IDX_W-1:0] inv_idx, low_idx;
    logic [Q_W-1:0]   low_q;

    always_comb begin
        hit_o       = 1'b0;
        hit_idx_o   = '0;
        have_inv    = 1'b0;
        inv_idx     = '0;
        any_valid_o = 1'b0;
        val_idx_o   = '0;
        low_idx     = '0;
        low_q       = q_i[0];
        for (int i = 0; i < ENTRIES; i++) begin
            if (!hit_o && match[i]) begin
                hit_o     = 1'b1;
                hit_idx_o = IDX_W'(i);
            end
            if (!have_inv && (st_i[i] == ENT_INVALID)) begin
                have_inv = 1'b1;
                inv_idx  = IDX_W'(i);
            end
            if (!any_valid_o && (st_i[i] == ENT_VALID)) begin
                any_valid_o = 1'b1;
                val_idx_o   = IDX_W'(i);
            end
        end
        // Strict compare keeps the lowest index on a tie.
        for (int i = 1; i < ENTRIES; i++) begin
            if (q_i[i] < low_q) begin
                low_q   = q_i[i];
                low_idx = IDX_W'(i);
            end
        end
        vic_idx_o = have_inv ? inv_idx : low_idx;
    end

endmodule

// File: rtl/speed_ctl.sv
module speed_ctl
    import stall_phase_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_valid_i,
    input  logic [CNT_W-1:0] ninstr_i,
    input  logic [CNT_W-1:0] stride_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic             speedup_o,
    output logic             slowed_o,
    output logic [CNT_W-1:0] ninstr_o,
    output logic [CNT_W-1:0] stride_o
);

    spd_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SPD_FAST:     if (any_valid_i)  st_d = SPD_REQ_SLOW;
            SPD_REQ_SLOW: if (ack_i)        st_d = SPD_SLOW;
            SPD_SLOW:     if (!any_valid_i) st_d = SPD_REQ_FAST;
            SPD_REQ_FAST: if (ack_i)        st_d = SPD_FAST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SPD_FAST;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ninstr_o <= '0;
            stride_o <= '0;
        end else if ((st_q == SPD_FAST) && any_valid_i) begin
            ninstr_o <= ninstr_i;
            stride_o <= stride_i;
        end
    end

    always_comb begin
        irq_o     = 1'b0;
        speedup_o = 1'b0;
        slowed_o  = 1'b0;
        unique case (st_q)
            SPD_FAST:     ;
            SPD_REQ_SLOW: irq_o = 1'b1;
            SPD_SLOW:     slowed_o = 1'b1;
            SPD_REQ_FAST: begin
                irq_o     = 1'b1;
                speedup_o = 1'b1;
                slowed_o  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/stall_phase_table.sv
module stall_phase_table
    import stall_phase_pkg::*;
#(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned PC_W    = 32,
    parameter int unsigned ID_W    = 8,
    parameter int unsigned CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_valid_i,
    input  logic [PC_W-1:0]  retire_pc_i,
    input  logic             mem_stall_i,
    input  logic             cfg_we_i,
    input  logic             cfg_sel_i,
    input  logic [ID_W-1:0]  cfg_wdata_i,
    input  logic             irq_ack_i,
    output logic             irq_o,
    output logic             irq_speedup_o,
    output logic             slowed_o,
    output logic [CNT_W-1:0] ninstr_o,
    output logic [CNT_W-1:0] stride_o
);

    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ID_W-1:0] owner_q, mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_q <= '0;
            mask_q  <= '1;
        end else if (cfg_we_i) begin
            if (cfg_sel_i) mask_q  <= cfg_wdata_i;
            else           owner_q <= cfg_wdata_i;
        end
    end

    logic [ENTRIES-1:0][1:0]       ent_st;
    logic [ENTRIES-1:0][PC_W-1:0]  ent_pc;
    logic [ENTRIES-1:0][ID_W-1:0]  ent_id;
    logic [ENTRIES-1:0][Q_W-1:0]   ent_q;
    logic [ENTRIES-1:0][CNT_W-1:0] ent_stride;
    logic [ENTRIES-1:0][CNT_W-1:0] ent_ninstr;

    logic             hit, any_valid;
    logic [IDX_W-1:0] hit_idx, vic_idx, val_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic alloc, stall_hit;
        assign alloc     = mem_stall_i && !hit && (vic_idx == IDX_W'(g));
        assign stall_hit = mem_stall_i &&  hit && (hit_idx == IDX_W'(g));

        stall_entry #(
            .PC_W  (PC_W),
            .ID_W  (ID_W),
            .CNT_W (CNT_W)
        ) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .retire_i    (retire_valid_i),
            .stall_hit_i (stall_hit),
            .alloc_i     (alloc),
            .pc_i        (retire_pc_i),
            .id_i        (owner_q),
            .state_o     (ent_st[g]),
            .pc_o        (ent_pc[g]),
            .id_o        (ent_id[g]),
            .q_o         (ent_q[g]),
            .stride_o    (ent_stride[g]),
            .ninstr_o    (ent_ninstr[g])
        );
    end

    stall_select #(
        .ENTRIES (ENTRIES),
        .PC_W    (PC_W),
        .ID_W    (ID_W),
        .IDX_W   (IDX_W)
    ) u_sel (
        .st_i        (ent_st),
        .pc_i        (ent_pc),
        .id_i        (ent_id),
        .q_i         (ent_q),
        .look_pc_i   (retire_pc_i),
        .owner_i     (owner_q),
        .mask_i      (mask_q),
        .hit_o       (hit),
        .hit_idx_o   (hit_idx),
        .vic_idx_o   (vic_idx),
        .any_valid_o (any_valid),
        .val_idx_o   (val_idx)
    );

    speed_ctl #(
        .CNT_W (CNT_W)
    ) u_spd (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_valid_i (any_valid),
        .ninstr_i    (ent_ninstr[val_idx]),
        .stride_i    (ent_stride[val_idx]),
        .ack_i       (irq_ack_i),
        .irq_o       (irq_o),
        .speedup_o   (irq_speedup_o),
        .slowed_o    (slowed_o),
        .ninstr_o    (ninstr_o),
        .stride_o    (stride_o)
    );

endmodule

// File: rtl/stall_phase_checks.sv
module stall_phase_checks #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_ack_i,
    input logic             irq_o,
    input logic             irq_speedup_o,
    input logic             slowed_o,
    input logic [CNT_W-1:0] ninstr_o,
    input logic [CNT_W-1:0] stride_o
);

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !irq_ack_i |=> irq_o); // R9

    AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !irq_ack_i |=> $stable(irq_speedup_o)); // R9

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && irq_ack_i |=> !irq_o); // R9

    AST_FLAG_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (slowed_o != $past(slowed_o)) |-> $past(irq_o && irq_ack_i)); // R10

    AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_speedup_o == slowed_o)); // R10

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !irq_ack_i |=> $stable(ninstr_o) && $stable(stride_o)); // R3

endmodule

bind stall_phase_table stall_phase_checks #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_ack_i     (irq_ack_i),
    .irq_o         (irq_o),
    .irq_speedup_o (irq_speedup_o),
    .slowed_o      (slowed_o),
    .ninstr_o      (ninstr_o),
    .stride_o      (stride_o)
);

// File: tb/sim_stall_phase_table.sv
module sim_stall_phase_table;

    localparam int PC_W = 32, ID_W = 8, CNT_W = 8, ENTRIES = 2;
    localparam int CMAX = (1 << CNT_W) - 1;
    localparam logic [31:0] PA = 32'h400, PB = 32'h800, PC = 32'hC00, PD = 32'h1000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             retire_valid = 1'b0;
    logic [PC_W-1:0]  retire_pc = '0;
    logic             mem_stall = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [ID_W-1:0]  cfg_wdata = '0;
    logic             irq_ack = 1'b0;
    logic             irq, irq_up, slowed;
    logic [CNT_W-1:0] ninstr, stride;

    stall_phase_table #(
        .ENTRIES (ENTRIES), .PC_W (PC_W), .ID_W (ID_W), .CNT_W (CNT_W)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .retire_valid_i (retire_valid), .retire_pc_i (retire_pc),
        .mem_stall_i (mem_stall),
        .cfg_we_i (cfg_we), .cfg_sel_i (cfg_sel), .cfg_wdata_i (cfg_wdata),
        .irq_ack_i (irq_ack),
        .irq_o (irq), .irq_speedup_o (irq_up), .slowed_o (slowed),
        .ninstr_o (ninstr), .stride_o (stride)
    );

    int cyc = 0, rets = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (retire_valid) rets <= rets + 1;
    end

    int  checks = 0, errors = 0;
    bit  done = 1'b0;
    bit  busy = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int sat(input int x);
        return (x > CMAX) ? CMAX : x;
    endfunction

    function automatic bit close(input int m, input int s);
        int d;
        d = (m >= s) ? m - s : s - m;
        return d <= (s >> 3);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle1();
        retire_valid = busy ? 1'b1 : 1'($urandom % 2);
        retire_pc    = 32'h8000_0000 | ($urandom & 32'h0000_FFFC);
        mem_stall    = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) idle1();
    endtask

    task automatic stall(input logic [31:0] pc, output int t, output int r);
        retire_valid = 1'b1;
        retire_pc    = pc;
        mem_stall    = 1'b1;
        @(negedge clk);
        mem_stall    = 1'b0;
        retire_valid = 1'b0;
        t = cyc;
        r = rets;
    endtask

    task automatic stall_after(input logic [31:0] pc, input int ref_t, input int s,
                               output int t, output int r);
        while (cyc < ref_t + s - 1) idle1();
        stall(pc, t, r);
    endtask

    task automatic cfg(input logic sel, input logic [ID_W-1:0] d);
        retire_valid = 1'b0;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; retire_valid = 1'b0; mem_stall = 1'b0; cfg_we = 1'b0;
        irq_ack = 1'b0; busy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int t0, t1, t2, t3, t4, t5, t6, r0, r1, r2, tx, rx;
        void'($urandom(32'd20240611));

        // R1: reset state
        do_reset();
        check("R1", "irq", int'(irq), 0);
        check("R1", "slowed", int'(slowed), 0);
        check("R1", "ninstr", int'(ninstr), 0);
        check("R1", "stride", int'(stride), 0);

        // R2 R3 R9: lock on a loop while unrelated retires flow past
        stall(PA, t0, r0);
        stall_after(PA, t0, 60, t1, r1);
        stall(PB, tx, rx);
        idle(20);
        stall_after(PA, t1, 60, t2, r2);
        idle1();
        check("R2", "irq after third stall", int'(irq), 1);
        check("R9", "direction slow-down", int'(irq_up), 0);
        check("R3", "stride", int'(stride), 60);
        check("R3", "ninstr", int'(ninstr), sat(r2 - r1));
        idle(5);
        check("R9", "request held", int'(irq), 1);
        check("R9", "flag before ack", int'(slowed), 0);
        ack();
        check("R9", "flag after ack", int'(slowed), 1);
        check("R9", "irq after ack", int'(irq), 0);

        // R5 R10: Q saturates at 3, three far strides drop the entry
        stall_after(PA, t2, 60, t3, r0);
        stall_after(PA, t3, 100, t4, r0);
        idle1();
        check("R5", "still valid after one miss", int'(irq), 0);
        stall_after(PA, t4, 60, t5, r0);
        idle1();
        check("R5", "still valid after two misses", int'(irq), 0);
        stall_after(PA, t5, 100, t6, r0);
        idle1();
        check("R10", "speed-up irq", int'(irq), 1);
        check("R10", "direction speed-up", int'(irq_up), 1);
        idle(3);
        check("R10", "flag held before ack", int'(slowed), 1);
        ack();
        check("R10", "flag cleared", int'(slowed), 0);
        check("R10", "irq cleared", int'(irq), 0);

        // R4: tolerance edges for stored stride 80 (tolerance 10)
        do_reset();
        stall(PA, t0, r0); stall_after(PA, t0, 80, t1, r1); stall_after(PA, t1, 90, t2, r2);
        idle1();
        check("R4", "+10 is close", int'(irq), 1);
        check("R4", "stride stored", int'(stride), 90);
        do_reset();
        stall(PA, t0, r0); stall_after(PA, t0, 80, t1, r1); stall_after(PA, t1, 70, t2, r2);
        idle1();
        check("R4", "-10 is close", int'(irq), 1);
        do_reset();
        stall(PA, t0, r0); stall_after(PA, t0, 80, t1, r1); stall_after(PA, t1, 91, t2, r2);
        idle(2);
        check("R4", "+11 is far", int'(irq), 0);

        // R6: a foreign owner misses; a widened mask hits again
        do_reset();
        cfg(1'b0, 8'd1);
        stall(PA, t0, r0); stall_after(PA, t0, 50, t1, r1);
        cfg(1'b0, 8'd2);
        stall(PA, tx, rx);
        idle(2);
        check("R6", "owner mismatch no lock", int'(irq), 0);
        cfg(1'b1, 8'hFC);
        stall_after(PA, t1, 50, t2, r2);
        idle1();
        check("R6", "masked owner hits", int'(irq), 1);
        check("R6", "stride", int'(stride), 50);

        // R7: tie on lowest Q evicts the lowest index
        do_reset();
        stall(PA, t0, r0); stall_after(PA, t0, 40, t1, r1);
        stall(PB, tx, rx);
        stall(PC, tx, rx);
        stall_after(PA, t1, 40, t2, r2);
        idle(2);
        check("R7", "tie evicted index 0", int'(irq), 0);

        // R7: the valid entry with higher Q survives two misses
        do_reset();
        stall(PA, t0, r0); stall_after(PA, t0, 40, t1, r1); stall_after(PA, t1, 40, t2, r2);
        idle1();
        check("R7", "lock before misses", int'(irq), 1);
        ack();
        stall(PB, tx, rx);
        stall(PC, tx, rx);
        stall(PD, tx, rx);
        idle(2);
        check("R7", "no speed-up irq", int'(irq), 0);
        check("R7", "still slowed", int'(slowed), 1);

        // R8: stride and work count saturate
        do_reset();
        busy = 1'b1;
        stall(PA, t0, r0); stall_after(PA, t0, 300, t1, r1); stall_after(PA, t1, 400, t2, r2);
        idle1();
        check("R8", "irq", int'(irq), 1);
        check("R8", "stride saturated", int'(stride), CMAX);
        check("R8", "ninstr saturated", int'(ninstr), sat(r2 - r1));
        busy = 1'b0;

        // R3 R4: random stride pairs
        for (int k = 0; k < 12; k++) begin
            int s, s2, d;
            bit exp;
            do_reset();
            s  = 16 + int'($urandom % 150);
            d  = int'($urandom % (s / 2 + 1)) - s / 4;
            s2 = s + d;
            exp = close(s2, s);
            stall(PA, t0, r0);
            stall_after(PA, t0, s, t1, r1);
            stall_after(PA, t1, s2, t2, r2);
            idle1();
            check("R4", "random lock decision", int'(irq), int'(exp));
            if (exp) begin
                check("R3", "random stride", int'(stride), s2);
                check("R3", "random ninstr", int'(ninstr), sat(r2 - r1));
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule